// File: doc/BRIEF.md
# Multi-Channel Serializing Transmitter

This block turns several lanes of parallel words into one serial bit stream per lane. Each lane's words are written from a core clock domain. The write side of each lane has its own enable, and each word goes into a small clock-crossing FIFO owned by that lane. On the serial side, a shared bit counter marks a word boundary once every `FACTOR` cycles of the fast bit clock. At each boundary every lane loads its next word into a shift register and then shifts it out, most significant bit first.

When a lane has no data at a boundary, it sends a word of zeros for that slot. A word-rate clock is derived from the same counter. Its period is `FACTOR` bit-clock cycles, and it rises on the cycle that carries the first bit of each word. A parameter can remove the FIFOs. In that case each serializer samples its slice of the parallel bus directly at the boundary.

There are two clears. One clears every lane's FIFO and serializer. The other clears only the clock-generation part. The lock indicator of the external clock source passes straight through the block.

Top module: `mc_serial_tx`

## Requirements
- R1: Lane k takes its word from bits [(k+1)*FACTOR-1 : k*FACTOR] of `wr_data`. Bit FACTOR-1 of that slice leaves on `ser_out[k]` first and bit 0 leaves last, with one bit per `bit_clk` cycle.
- R2: Legal values of `FACTOR` are 3 to 12, 14, 16, 18 and 20. Elaboration fails for any other value, and the package function `factor_ok` returns 1 exactly for the legal set.
- R3: A lane stores a word only on a `core_clk` edge where its own bit of `wr_en` is high. Data presented while that bit is low never appears on the lane's serial output.
- R4: `full[k]` rises once FIFO_DEPTH words are held and not yet read. A write to a full lane is discarded, and the lane's stored words are left unchanged.
- R5: `empty[k]` is high while lane k holds no word. At a boundary with an empty FIFO, the lane sends FACTOR zero bits and consumes nothing.
- R6: `word_clk` has a period of FACTOR bit-clock cycles. It is high for FACTOR/2 of them, and it rises in the cycle that carries bit FACTOR-1 of each new word.
- R7: All lanes load their next word on the same `bit_clk` cycle, so equal-index bits of all lanes leave together.
- R8: With BYPASS=1, no FIFO exists. Each serializer loads its slice of `wr_data` at the boundary, and `full` and `empty` are held low.
- R9: `arst` empties every FIFO (empty=1, full=0) and drives every serial output low at once. After release, lanes send zero words until new data is written.
- R10: While `clkgen_arst` is high, the bit counter holds, no word is loaded and `word_clk` is held high. `clk_locked` follows `clk_locked_in` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| core_clk | input | 1 | Write-side clock |
| bit_clk | input | 1 | Serial bit clock |
| arst | input | 1 | Asynchronous clear of FIFOs and serializers, active high |
| clkgen_arst | input | 1 | Asynchronous clear of the bit counter and word clock, active high |
| wr_en | input | CHANNELS | Per-lane write enable |
| wr_data | input | FACTOR*CHANNELS | Parallel words, lane k in slice k |
| clk_locked_in | input | 1 | Lock status of the external bit-clock source |
| ser_out | output | CHANNELS | Serial data, one bit per lane |
| word_clk | output | 1 | Word-rate clock |
| full | output | CHANNELS | Lane FIFO full, core_clk domain |
| empty | output | CHANNELS | Lane FIFO empty, bit_clk domain |
| clk_locked | output | 1 | Copy of clk_locked_in |

## Verification
The FIFOs drain one word every FACTOR bit cycles without pause, and the writer is slower than that unless it bursts. Because of this, a full FIFO and a write dropped against it are hard to produce from the ports. The bench holds the clock-generation clear to freeze all reads. It then writes more words than the depth, with lanes enabled unevenly, and afterwards releases the counter to confirm that only the first FIFO_DEPTH words appear, followed by zero words. A random streaming phase then keeps the FIFOs near full under flow control by the `full` flag.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

   function automatic bit factor_ok(input int f);
      return (f >= 3 && f <= 12) || f == 14 || f == 16 || f == 18 || f == 20;
   endfunction

   function automatic bit depth_ok(input int d);
      return (d >= 4) && ((d & (d - 1)) == 0);
   endfunction

endpackage

// File: rtl/ptx_wordclk.sv
module ptx_wordclk #(
   parameter int FACTOR = 8
) (
   input  logic bit_clk,
   input  logic clkgen_arst,
   output logic load_tick,
   output logic word_clk
);
   localparam int CW   = $clog2(FACTOR);
   localparam int HALF = FACTOR / 2;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic          wclk_q;

   assign load_tick = (cnt_q == CW'(FACTOR - 1));
   assign cnt_nxt   = load_tick ? '0 : cnt_q + 1'b1;

   always_ff @(posedge bit_clk or posedge clkgen_arst) begin
      if (clkgen_arst) begin
         cnt_q  <= '0;
         wclk_q <= 1'b1;
      end else begin
         cnt_q  <= cnt_nxt;
         wclk_q <= (cnt_nxt < CW'(HALF));
      end
   end

   assign word_clk = wclk_q;

   assert_wclk_rise_R6: assert property (@(posedge bit_clk) disable iff (clkgen_arst)
      load_tick |=> $rose(word_clk));
   assert_tick_spacing_R7: assert property (@(posedge bit_clk) disable iff (clkgen_arst)
      load_tick |=> !load_tick);
endmodule

// File: rtl/ptx_afifo.sv
module ptx_afifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         arst,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         full,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   if (!ptx_pkg::depth_ok(DEPTH)) begin : g_bad_depth
      $error("ptx_afifo: DEPTH must be a power of two, at least 4");
   end

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wbin, wgray, rbin, rgray;
   logic [AW:0]  rg_s1, rg_s2, wg_s1, wg_s2;
   logic [AW:0]  wbin_n, rbin_n;
   logic         do_wr, do_rd;

   assign full   = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
   assign empty  = (rgray == wg_s2);
   assign do_wr  = wr_en && !full;
   assign do_rd  = rd_en && !empty;
   assign wbin_n = wbin + 1'b1;
   assign rbin_n = rbin + 1'b1;

   always_ff @(posedge wclk or posedge arst) begin
      if (arst) begin
         wbin  <= '0;
         wgray <= '0;
         rg_s1 <= '0;
         rg_s2 <= '0;
      end else begin
         rg_s1 <= rgray;
         rg_s2 <= rg_s1;
         if (do_wr) begin
            wbin  <= wbin_n;
            wgray <= wbin_n ^ (wbin_n >> 1);
         end
      end
   end

   always_ff @(posedge wclk) begin
      if (do_wr) mem[wbin[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge rclk or posedge arst) begin
      if (arst) begin
         rbin  <= '0;
         rgray <= '0;
         wg_s1 <= '0;
         wg_s2 <= '0;
      end else begin
         wg_s1 <= wgray;
         wg_s2 <= wg_s1;
         if (do_rd) begin
            rbin  <= rbin_n;
            rgray <= rbin_n ^ (rbin_n >> 1);
         end
      end
   end

   assign rd_data = mem[rbin[AW-1:0]];

   assert_drop_when_full_R4: assert property (@(posedge wclk) disable iff (arst)
      (wr_en && full) |=> $stable(wbin));
   assert_no_pop_empty_R5: assert property (@(posedge rclk) disable iff (arst)
      (rd_en && empty) |=> $stable(rbin));
endmodule

// File: rtl/ptx_serializer.sv
module ptx_serializer #(
   parameter int FACTOR = 8
) (
   input  logic              bit_clk,
   input  logic              arst,
   input  logic              load,
   input  logic [FACTOR-1:0] word,
   output logic              ser_out
);
   logic [FACTOR-1:0] sh_q;

   always_ff @(posedge bit_clk or posedge arst) begin
      if (arst)      sh_q <= '0;
      else if (load) sh_q <= word;
      else           sh_q <= {sh_q[FACTOR-2:0], 1'b0};
   end

   assign ser_out = sh_q[FACTOR-1];
endmodule

// File: rtl/mc_serial_tx.sv
module mc_serial_tx #(
   parameter int CHANNELS   = 2,
   parameter int FACTOR     = 8,
   parameter int FIFO_DEPTH = 4,
   parameter bit BYPASS     = 1'b0
) (
   input  logic                         core_clk,
   input  logic                         bit_clk,
   input  logic                         arst,
   input  logic                         clkgen_arst,
   input  logic [CHANNELS-1:0]          wr_en,
   input  logic [FACTOR*CHANNELS-1:0]   wr_data,
   input  logic                         clk_locked_in,
   output logic [CHANNELS-1:0]          ser_out,
   output logic                         word_clk,
   output logic [CHANNELS-1:0]          full,
   output logic [CHANNELS-1:0]          empty,
   output logic                         clk_locked
);
   if (!ptx_pkg::factor_ok(FACTOR)) begin : g_bad_factor
      $error("mc_serial_tx: FACTOR must be 3..12, 14, 16, 18 or 20");
   end

   logic load_tick;

   ptx_wordclk #(.FACTOR(FACTOR)) u_wordclk (
      .bit_clk     (bit_clk),
      .clkgen_arst (clkgen_arst),
      .load_tick   (load_tick),
      .word_clk    (word_clk)
   );

   assign clk_locked = clk_locked_in;

   for (genvar k = 0; k < CHANNELS; k++) begin : g_lane
      logic [FACTOR-1:0] lane_word;

      if (BYPASS) begin : g_direct
         assign lane_word = wr_data[k*FACTOR +: FACTOR];
         assign full[k]   = 1'b0;
         assign empty[k]  = 1'b0;
      end else begin : g_fifo
         logic [FACTOR-1:0] head;
         logic              f_full, f_empty;

         ptx_afifo #(.W(FACTOR), .DEPTH(FIFO_DEPTH)) u_fifo (
            .wclk    (core_clk),
            .rclk    (bit_clk),
            .arst    (arst),
            .wr_en   (wr_en[k]),
            .wr_data (wr_data[k*FACTOR +: FACTOR]),
            .full    (f_full),
            .rd_en   (load_tick),
            .rd_data (head),
            .empty   (f_empty)
         );

         assign lane_word = f_empty ? '0 : head;
         assign full[k]   = f_full;
         assign empty[k]  = f_empty;

         assert_underrun_zero_R5: assert property (@(posedge bit_clk) disable iff (arst)
            (load_tick && f_empty) |=> (ser_out[k] == 1'b0));
      end

      ptx_serializer #(.FACTOR(FACTOR)) u_ser (
         .bit_clk (bit_clk),
         .arst    (arst),
         .load    (load_tick),
         .word    (lane_word),
         .ser_out (ser_out[k])
      );
   end

   assert_clear_outputs_R9: assert property (@(posedge bit_clk)
      arst |-> (ser_out == '0));
endmodule

// File: tb/tb_mc_serial_tx.sv
module tb_mc_serial_tx;
   localparam int CH = 2;
   localparam int F  = 8;
   localparam int D  = 4;
   localparam int N  = 20;

   logic core_clk = 1'b0;
   logic bit_clk  = 1'b0;
   logic arst     = 1'b1;
   logic cg_arst  = 1'b1;
   logic [CH-1:0]   wr_en   = '0;
   logic [F*CH-1:0] wr_data = '0;
   logic [F*CH-1:0] byp_data = '0;
   logic lock_in = 1'b0;

   logic [CH-1:0] ser_out, full, empty, ser_b, full_b, empty_b;
   logic word_clk, word_clk_b, locked, locked_b;

   always #2 bit_clk  = ~bit_clk;
   always #3.5 core_clk = ~core_clk;

   mc_serial_tx #(.CHANNELS(CH), .FACTOR(F), .FIFO_DEPTH(D), .BYPASS(1'b0)) dut (
      .core_clk(core_clk), .bit_clk(bit_clk), .arst(arst), .clkgen_arst(cg_arst),
      .wr_en(wr_en), .wr_data(wr_data), .clk_locked_in(lock_in),
      .ser_out(ser_out), .word_clk(word_clk), .full(full), .empty(empty), .clk_locked(locked));

   mc_serial_tx #(.CHANNELS(CH), .FACTOR(F), .FIFO_DEPTH(D), .BYPASS(1'b1)) dut_bypass (
      .core_clk(core_clk), .bit_clk(bit_clk), .arst(arst), .clkgen_arst(cg_arst),
      .wr_en('0), .wr_data(byp_data), .clk_locked_in(lock_in),
      .ser_out(ser_b), .word_clk(word_clk_b), .full(full_b), .empty(empty_b), .clk_locked(locked_b));

   int nchecks = 0;
   int nerr = 0;
   logic [F-1:0] frame_d [CH];
   logic [F-1:0] frame_b [CH];
   logic [F-1:0] exp_s [CH][N];
   int cnt_w [CH];

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit legal_f(input int f);
      case (f)
         3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 14, 16, 18, 20: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // Waits for the next rise of word_clk and captures one word per lane, first bit = MSB.
   task automatic get_frame();
      logic prev;
      int guard;
      prev = word_clk;
      guard = 0;
      while (guard < 4 * F) begin
         @(negedge bit_clk);
         if (word_clk && !prev) break;
         prev = word_clk;
         guard++;
      end
      for (int i = 0; i < F; i++) begin
         if (i > 0) @(negedge bit_clk);
         for (int c = 0; c < CH; c++) begin
            frame_d[c][F-1-i] = ser_out[c];
            frame_b[c][F-1-i] = ser_b[c];
         end
      end
   endtask

   task automatic core_write(input logic [CH-1:0] en, input logic [F*CH-1:0] d);
      @(negedge core_clk);
      wr_en = en;
      wr_data = d;
      @(negedge core_clk);
      wr_en = '0;
   endtask

   initial begin
      #200000;
      nerr++;
      nchecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

   initial begin
      logic [F-1:0] w0 [D+2];
      logic [F-1:0] w1 [D+2];
      void'($urandom(32'd20240611));

      // reset state
      repeat (5) @(negedge bit_clk);
      check(empty == '1, "R9", "empty at reset", empty, 3);
      check(full == '0, "R9", "full at reset", full, 0);
      check(ser_out == '0, "R9", "ser_out at reset", ser_out, 0);
      check(word_clk == 1'b1, "R10", "word_clk held in clock clear", word_clk, 1);

      // R2: legality function
      begin
         int bad;
         bad = 0;
         for (int f = 1; f <= 24; f++)
            if (ptx_pkg::factor_ok(f) != legal_f(f)) bad++;
         check(bad == 0, "R2", "factor legality mismatches", bad, 0);
      end

      // R10: lock pass-through
      lock_in = 1'b1; #1;
      check(locked == 1'b1, "R10", "lock high", locked, 1);
      lock_in = 1'b0; #1;
      check(locked == 1'b0, "R10", "lock low", locked, 0);

      // Fill with reads frozen: overflow lane 0, lane 1 enabled only twice
      arst = 1'b0;
      for (int i = 0; i < D + 2; i++) begin
         logic [CH-1:0] en;
         w0[i] = F'($urandom);
         w1[i] = F'($urandom);
         if (i == 0) begin w0[i][F-1] = 1'b1; w1[i][F-1] = 1'b1; end
         en = {(i < 2), 1'b1};
         core_write(en, {w1[i], w0[i]});
      end
      repeat (10) @(negedge bit_clk);
      @(negedge core_clk);
      check(full[0] == 1'b1, "R4", "lane0 full after depth writes", full[0], 1);
      check(full[1] == 1'b0, "R4", "lane1 not full", full[1], 0);
      check(empty == '0, "R5", "both lanes hold data", empty, 0);
      check(word_clk == 1'b1 && ser_out == '0, "R10", "no load while clock clear",
            {word_clk, ser_out}, 4);

      @(negedge bit_clk);
      cg_arst = 1'b0;
      for (int i = 0; i < D + 2; i++) begin
         logic [F-1:0] e0, e1;
         get_frame();
         e0 = (i < D) ? w0[i] : '0;
         e1 = (i < 2) ? w1[i] : '0;
         check(frame_d[0] == e0, (i < D) ? "R1" : "R4", $sformatf("lane0 word %0d", i),
               frame_d[0], e0);
         check(frame_d[1] == e1, (i < 2) ? "R3" : "R5", $sformatf("lane1 word %0d", i),
               frame_d[1], e1);
      end
      check(empty == '1, "R5", "empty after drain", empty, 3);

      // R6: word clock shape
      begin
         int hi, per;
         logic prev;
         prev = word_clk;
         forever begin
            @(negedge bit_clk);
            if (word_clk && !prev) break;
            prev = word_clk;
         end
         hi = 0; per = 0;
         do begin
            if (word_clk) hi++;
            per++;
            prev = word_clk;
            @(negedge bit_clk);
         end while (!(word_clk && !prev));
         check(per == F, "R6", "word_clk period", per, F);
         check(hi == F / 2, "R6", "word_clk high cycles", hi, F / 2);
      end

      // Random streaming under full-flag flow control
      cnt_w[0] = 0; cnt_w[1] = 0;
      fork
         begin
            while (cnt_w[0] < N || cnt_w[1] < N) begin
               logic [CH-1:0] en;
               logic [F*CH-1:0] d;
               @(negedge core_clk);
               en = '0;
               d = (F*CH)'($urandom);
               for (int c = 0; c < CH; c++) begin
                  if (cnt_w[c] < N && !full[c] && (cnt_w[c] < 3 || $urandom_range(3) != 0)) begin
                     logic [F-1:0] w;
                     w = F'($urandom);
                     if (cnt_w[c] == 0) w[F-1] = 1'b1;
                     exp_s[c][cnt_w[c]] = w;
                     d[c*F +: F] = w;
                     en[c] = 1'b1;
                     cnt_w[c]++;
                  end
               end
               wr_en = en;
               wr_data = d;
            end
            @(negedge core_clk);
            wr_en = '0;
         end
         begin
            int got [CH];
            int errs [CH];
            bit started [CH];
            for (int c = 0; c < CH; c++) begin got[c] = 0; errs[c] = 0; started[c] = 0; end
            for (int f = 0; f < 200 && (got[0] < N || got[1] < N); f++) begin
               get_frame();
               for (int c = 0; c < CH; c++) begin
                  if (!started[c] && frame_d[c] == '0) continue;
                  started[c] = 1'b1;
                  if (got[c] < N) begin
                     if (frame_d[c] !== exp_s[c][got[c]]) errs[c]++;
                     got[c]++;
                  end
               end
            end
            for (int c = 0; c < CH; c++) begin
               check(errs[c] == 0, "R7", $sformatf("lane%0d stream mismatches", c), errs[c], 0);
               check(got[c] == N, "R1", $sformatf("lane%0d stream words", c), got[c], N);
            end
         end
      join

      // R8: bypass instance samples its slices at the boundary
      for (int i = 0; i < 3; i++) begin
         logic [F*CH-1:0] b;
         get_frame();
         b = (F*CH)'($urandom);
         byp_data = b;
         get_frame();
         check(frame_b[0] == b[F-1:0], "R8", "bypass lane0 word", frame_b[0], b[F-1:0]);
         check(frame_b[1] == b[2*F-1:F], "R8", "bypass lane1 word", frame_b[1], b[2*F-1:F]);
      end
      check(full_b == '0 && empty_b == '0, "R8", "bypass flags low", {full_b, empty_b}, 0);

      // R9: clear while holding data
      @(negedge bit_clk);
      cg_arst = 1'b1;
      core_write(2'b11, {F'(8'hA5), F'(8'h3C)});
      repeat (8) @(negedge bit_clk);
      check(empty == '0, "R9", "data held before clear", empty, 0);
      arst = 1'b1;
      #1;
      check(empty == '1 && full == '0, "R9", "flags after clear", {full, empty}, 3);
      check(ser_out == '0, "R9", "ser_out after clear", ser_out, 0);
      @(negedge bit_clk);
      arst = 1'b0;
      @(negedge bit_clk);
      cg_arst = 1'b0;
      get_frame();
      check(frame_d[0] == '0 && frame_d[1] == '0, "R9", "zero word after clear",
            {frame_d[1], frame_d[0]}, 0);

      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end
endmodule